// File: doc/BRIEF.md
# Rank-Based Ready Instruction Picker

This block sits between an issue queue and the execution units of an out-of-order core. Each cycle it looks at every queue entry. An entry offers a valid bit, an age (its sequence index, where a smaller value means older), the number of known consumers waiting on its result, and a one-hot mask that names the execution resource it needs. The block forms a signed priority score for each entry: the age minus the consumer count. Among the entries whose resource is free, it names the one with the lowest score. This favours old instructions, and it also favours instructions that many others are waiting on.

The pick is combinational and is presented on a valid/ready pair. `pick_valid` means `pick_idx` names a legal winner in this cycle. `pick_ready` from the issue stage means an issue attempt happens on this clock edge. Back-pressure has no state: while `pick_ready` is low, the pick just follows the entry inputs, so it holds as long as they hold. A registered busy mask records, for each attempt cycle, which resources turned away a valid entry. The mask is rebuilt from zero on every clock edge, so it never accumulates across cycles.

Top module: `rank_picker`

## Requirements
- R1: Each entry's score is a signed value equal to its age minus its consumer count. The score may be negative, for example age 2 with 9 consumers gives -7, and that entry beats an entry with score 0.
- R2: Among the candidates, the entry with the lowest score is picked.
- R3: When scores are equal, the entry with the smaller age wins. When age is also equal, the lower entry index wins.
- R4: An entry is a candidate only when its valid bit is set and the bitwise AND of its resource mask with `res_avail` is nonzero. Invalid entries and blocked entries never win, whatever their score.
- R5: When no entry is a candidate, `pick_valid` is 0 and `pick_idx` is 0.
- R6: After a clock edge at which `pick_ready` was 1, `busy_mask` equals the OR, over all valid entries, of (resource mask AND NOT `res_avail`). Bit k stands for resource k.
- R7: `busy_mask` is rebuilt on every edge. It is all zero after an edge where `pick_ready` was 0, and after an edge where no valid entry was blocked.
- R8: While `rst_n` is low, `busy_mask` is cleared to zero.
- R9: `pick_valid` and `pick_idx` depend only on the entry inputs and `res_avail` in the same cycle. They do not depend on `pick_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | N | Per-entry valid bit |
| ent_age | input | N*AGE_W | Per-entry sequence index, entry i at bits [i*AGE_W +: AGE_W] |
| ent_users | input | N*USR_W | Per-entry known consumer count |
| ent_res | input | N*RES_N | Per-entry one-hot resource mask |
| res_avail | input | RES_N | Resources free this cycle, bit k = resource k |
| pick_ready | input | 1 | Issue stage accepts a pick this edge |
| pick_valid | output | 1 | A winner exists |
| pick_idx | output | IDX_W | Index of the winning entry |
| busy_mask | output | RES_N | Resources that blocked a valid entry at the last attempt |

## Verification
On every cycle, the assertions check the following. The winner is a real candidate. No other candidate outranks the winner under the score and tie rules. The valid flag drops exactly when no candidate exists. The busy mask equals the blocked-resource OR of the previous attempt, and it is zero after an edge with no attempt. Only the bench's scenarios can show that the score arithmetic handles negative values and wide ranges: they sweep one entry's age and consumer count against a fixed rival. The scenarios also cover tie-breaking between equal scores, and the fact that the pick ignores back-pressure. Each of these results is compared against an arithmetic model written in the bench.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int DEF_N     = 8;
  localparam int DEF_RES_N = 8;
  localparam int DEF_AGE_W = 8;
  localparam int DEF_USR_W = 4;

  // True when (ra, aa) outranks (rb, ab): lower score, then older age.
  function automatic logic outranks(input logic signed [31:0] ra,
                                    input logic [31:0] aa,
                                    input logic signed [31:0] rb,
                                    input logic [31:0] ab);
    return (ra < rb) || ((ra == rb) && (aa < ab));
  endfunction
endpackage

// File: rtl/rp_score.sv
module rp_score #(
  parameter int N      = 8,
  parameter int RES_N  = 8,
  parameter int AGE_W  = 8,
  parameter int USR_W  = 4,
  parameter int RANK_W = 10
) (
  input  logic [N-1:0]        ent_valid,
  input  logic [N*AGE_W-1:0]  ent_age,
  input  logic [N*USR_W-1:0]  ent_users,
  input  logic [N*RES_N-1:0]  ent_res,
  input  logic [RES_N-1:0]    res_avail,
  output logic [N*RANK_W-1:0] rank_flat,
  output logic [N-1:0]        cand,
  output logic [N*RES_N-1:0]  blk_flat
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [RANK_W-1:0] age_x;
    logic [RANK_W-1:0] usr_x;
    logic [RES_N-1:0]  res_i;
    assign age_x = RANK_W'(ent_age[i*AGE_W +: AGE_W]);
    assign usr_x = RANK_W'(ent_users[i*USR_W +: USR_W]);
    assign res_i = ent_res[i*RES_N +: RES_N];
    assign rank_flat[i*RANK_W +: RANK_W] = age_x - usr_x;
    assign cand[i] = ent_valid[i] && ((res_i & res_avail) != '0);
    assign blk_flat[i*RES_N +: RES_N] = ent_valid[i] ? (res_i & ~res_avail) : '0;
  end
endmodule

// File: rtl/rp_select.sv
module rp_select
  import rp_pkg::*;
#(
  parameter int N      = 8,
  parameter int AGE_W  = 8,
  parameter int RANK_W = 10,
  parameter int IDX_W  = 3
) (
  input  logic [N-1:0]        cand,
  input  logic [N*RANK_W-1:0] rank_flat,
  input  logic [N*AGE_W-1:0]  ent_age,
  output logic                win_valid,
  output logic [IDX_W-1:0]    win_idx
);
  logic signed [31:0] best_r;
  logic [31:0]        best_a;
  logic signed [31:0] cur_r;
  logic [31:0]        cur_a;

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best_r    = '0;
    best_a    = '0;
    for (int i = 0; i < N; i++) begin
      cur_r = 32'(signed'(rank_flat[i*RANK_W +: RANK_W]));
      cur_a = 32'(ent_age[i*AGE_W +: AGE_W]);
      if (cand[i] && (!win_valid || outranks(cur_r, cur_a, best_r, best_a))) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        best_r    = cur_r;
        best_a    = cur_a;
      end
    end
  end
endmodule

// File: rtl/rp_busy.sv
module rp_busy #(
  parameter int N     = 8,
  parameter int RES_N = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               attempt,
  input  logic [N*RES_N-1:0] blk_flat,
  output logic [RES_N-1:0]   busy_q
);
  logic [RES_N-1:0] blk_or;

  always_comb begin
    blk_or = '0;
    for (int i = 0; i < N; i++) blk_or |= blk_flat[i*RES_N +: RES_N];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       busy_q <= '0;
    else if (attempt) busy_q <= blk_or;
    else              busy_q <= '0;
  end
endmodule

// File: rtl/rank_picker.sv
module rank_picker
  import rp_pkg::*;
#(
  parameter int N     = DEF_N,
  parameter int RES_N = DEF_RES_N,
  parameter int AGE_W = DEF_AGE_W,
  parameter int USR_W = DEF_USR_W,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
  localparam int RANK_W = ((AGE_W > USR_W) ? AGE_W : USR_W) + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       ent_valid,
  input  logic [N*AGE_W-1:0] ent_age,
  input  logic [N*USR_W-1:0] ent_users,
  input  logic [N*RES_N-1:0] ent_res,
  input  logic [RES_N-1:0]   res_avail,
  input  logic               pick_ready,
  output logic               pick_valid,
  output logic [IDX_W-1:0]   pick_idx,
  output logic [RES_N-1:0]   busy_mask
);
  logic [N*RANK_W-1:0] rank_flat;
  logic [N-1:0]        cand;
  logic [N*RES_N-1:0]  blk_flat;

  rp_score #(.N(N), .RES_N(RES_N), .AGE_W(AGE_W), .USR_W(USR_W), .RANK_W(RANK_W)) u_score (
    .ent_valid (ent_valid),
    .ent_age   (ent_age),
    .ent_users (ent_users),
    .ent_res   (ent_res),
    .res_avail (res_avail),
    .rank_flat (rank_flat),
    .cand      (cand),
    .blk_flat  (blk_flat)
  );

  rp_select #(.N(N), .AGE_W(AGE_W), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_sel (
    .cand      (cand),
    .rank_flat (rank_flat),
    .ent_age   (ent_age),
    .win_valid (pick_valid),
    .win_idx   (pick_idx)
  );

  rp_busy #(.N(N), .RES_N(RES_N)) u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .attempt  (pick_ready),
    .blk_flat (blk_flat),
    .busy_q   (busy_mask)
  );
endmodule

// File: rtl/rank_picker_chk.sv
module rank_picker_chk #(
  parameter int N      = 8,
  parameter int RES_N  = 8,
  parameter int AGE_W  = 8,
  parameter int USR_W  = 4,
  parameter int IDX_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N-1:0]       ent_valid,
  input logic [N*AGE_W-1:0] ent_age,
  input logic [N*USR_W-1:0] ent_users,
  input logic [N*RES_N-1:0] ent_res,
  input logic [RES_N-1:0]   res_avail,
  input logic               pick_ready,
  input logic               pick_valid,
  input logic [IDX_W-1:0]   pick_idx,
  input logic [RES_N-1:0]   busy_mask
);
  logic             any_cand;
  logic             win_is_cand;
  logic             beaten;
  logic [RES_N-1:0] exp_blk;
  int               sc [N];
  int               ag [N];
  logic [N-1:0]     ok;

  always_comb begin
    any_cand = 1'b0;
    exp_blk  = '0;
    for (int i = 0; i < N; i++) begin
      ok[i] = ent_valid[i] && ((ent_res[i*RES_N +: RES_N] & res_avail) != '0);
      ag[i] = int'(ent_age[i*AGE_W +: AGE_W]);
      sc[i] = ag[i] - int'(ent_users[i*USR_W +: USR_W]);
      any_cand |= ok[i];
      if (ent_valid[i]) exp_blk |= ent_res[i*RES_N +: RES_N] & ~res_avail;
    end
    win_is_cand = ok[pick_idx];
    beaten = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ok[i] && (i != int'(pick_idx)) &&
          ((sc[i] < sc[pick_idx]) ||
           ((sc[i] == sc[pick_idx]) && (ag[i] < ag[pick_idx])) ||
           ((sc[i] == sc[pick_idx]) && (ag[i] == ag[pick_idx]) && (i < int'(pick_idx)))))
        beaten = 1'b1;
    end
  end

  // R4: a reported winner is always a legal candidate
  p_win_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> win_is_cand);
  // R2 / R3: no other candidate outranks the winner
  p_win_best_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> !beaten);
  // R5: valid flag tracks candidate existence
  p_valid_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid == any_cand);
  // R5: index is zero when idle
  p_idle_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_valid |-> (pick_idx == '0));
  // R6: busy mask reflects last attempt's blocked resources
  p_busy_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pick_ready |=> (busy_mask == $past(exp_blk)));
  // R7: no attempt leaves a clean mask
  p_busy_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_ready |=> (busy_mask == '0));
endmodule

bind rank_picker rank_picker_chk #(
  .N(N), .RES_N(RES_N), .AGE_W(AGE_W), .USR_W(USR_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_age(ent_age),
  .ent_users(ent_users), .ent_res(ent_res), .res_avail(res_avail),
  .pick_ready(pick_ready), .pick_valid(pick_valid), .pick_idx(pick_idx),
  .busy_mask(busy_mask)
);

// File: tb/rank_picker_tb.sv
module rank_picker_tb;
  localparam int N = 8, RN = 8, AW = 8, UW = 4, IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    ent_valid = '0;
  logic [N*AW-1:0] ent_age   = '0;
  logic [N*UW-1:0] ent_users = '0;
  logic [N*RN-1:0] ent_res   = '0;
  logic [RN-1:0]   res_avail = '0;
  logic            pick_ready = 1'b0;
  logic            pick_valid;
  logic [IW-1:0]   pick_idx;
  logic [RN-1:0]   busy_mask;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;

  rank_picker u_dut (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_age(ent_age),
    .ent_users(ent_users), .ent_res(ent_res), .res_avail(res_avail),
    .pick_ready(pick_ready), .pick_valid(pick_valid), .pick_idx(pick_idx),
    .busy_mask(busy_mask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic set_ent(input int i, input logic v, input int age, input int usr, input int res);
    ent_valid[i] = v;
    ent_age[i*AW +: AW] = AW'(age);
    ent_users[i*UW +: UW] = UW'(usr);
    ent_res[i*RN +: RN] = RN'(1) << res;
  endtask

  // Model: returns {valid, idx}; scores computed arithmetically
  function automatic logic [31:0] model_pick();
    int best = -1, bs = 0, ba = 0;
    for (int i = 0; i < N; i++) begin
      int a = int'(ent_age[i*AW +: AW]);
      int s = a - int'(ent_users[i*UW +: UW]);
      if (ent_valid[i] && ((ent_res[i*RN +: RN] & res_avail) != 0))
        if (best < 0 || s < bs || (s == bs && a < ba)) begin
          best = i; bs = s; ba = a;
        end
    end
    return (best < 0) ? 32'h0 : (32'h100 | 32'(best));
  endfunction

  function automatic logic [RN-1:0] model_busy();
    logic [RN-1:0] m = '0;
    for (int i = 0; i < N; i++)
      if (ent_valid[i]) m |= ent_res[i*RN +: RN] & ~res_avail;
    return pick_ready ? m : '0;
  endfunction

  // Inputs already set at negedge; check pick now, busy after the edge.
  task automatic run_vec(input string req_pick, input string req_busy);
    logic [31:0] ep;
    logic [RN-1:0] eb;
    #1;
    ep = model_pick();
    eb = model_busy();
    chk(req_pick, {23'b0, pick_valid, 5'b0, pick_idx}, ep);
    @(posedge clk); #1;
    chk(req_busy, 32'(busy_mask), 32'(eb));
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R8 reset busy", 32'(busy_mask), 0);
    @(negedge clk); rst_n = 1'b1;
    pick_ready = 1'b1;
    res_avail = '1;
    // R5: nothing valid
    run_vec("R5 empty", "R7 empty busy");
    // R1/R2: sweep entry 2 score against fixed rival at entry 5 (score 37)
    for (int a = 0; a < 256; a += 17)
      for (int u = 0; u < 16; u++) begin
        ent_valid = '0;
        set_ent(5, 1, 40, 3, 1);
        set_ent(2, 1, a, u, 4);
        run_vec("R1 R2 sweep", "R7 sweep busy");
      end
    // R1: negative score beats zero score
    ent_valid = '0;
    set_ent(0, 1, 9, 9, 0);
    set_ent(7, 1, 2, 9, 0);
    run_vec("R1 negative", "R7 neg busy");
    chk("R1 negative idx", 32'(pick_idx), 7);
    // R3: equal scores, older wins
    ent_valid = '0;
    set_ent(1, 1, 20, 5, 2);
    set_ent(6, 1, 18, 3, 3);
    run_vec("R3 tie age", "R7 tie busy");
    chk("R3 tie idx", 32'(pick_idx), 6);
    // R3: equal score and age, lower index wins
    ent_valid = '0;
    set_ent(3, 1, 10, 1, 2);
    set_ent(4, 1, 10, 1, 2);
    #1 chk("R3 index tie", 32'(pick_idx), 3);
    @(negedge clk);
    // R4/R6: best entry blocked by its resource
    ent_valid = '0;
    set_ent(0, 1, 1, 0, 5);
    set_ent(4, 1, 30, 0, 2);
    res_avail = 8'hDF;
    run_vec("R4 blocked best", "R6 blocked bit5");
    chk("R4 blocked idx", 32'(pick_idx), 4);
    // R5/R6: every valid entry blocked
    res_avail = 8'hDB;
    #1 chk("R5 all blocked", 32'(pick_valid), 0);
    @(posedge clk); #1;
    chk("R6 all blocked busy", 32'(busy_mask), 32'h24);
    @(negedge clk);
    // R7/R9: back-pressure, pick unaffected, busy clean
    pick_ready = 1'b0;
    res_avail = 8'hFF;
    ent_valid = '0;
    set_ent(2, 1, 50, 0, 1);
    set_ent(5, 1, 60, 0, 6);
    res_avail = 8'hBF;
    run_vec("R9 no ready pick", "R7 no ready busy");
    chk("R9 idx held", 32'(pick_idx), 2);
    pick_ready = 1'b1;
    // Random sweep covering all requirements
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < N; i++) begin
        lfsr = nxt(lfsr);
        set_ent(i, lfsr[0] | lfsr[1], int'(lfsr[15:8]), int'(lfsr[19:16]), int'(lfsr[22:20]));
      end
      lfsr = nxt(lfsr);
      res_avail = lfsr[7:0] | lfsr[15:8];
      pick_ready = lfsr[20] | lfsr[21];
      run_vec("R2 R3 R4 R5 R9 random", "R6 R7 random busy");
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule